// File: doc/BRIEF.md
# I/O Chip-Select Decoder with Programmable Block Size

This block sits between the ISA I/O address bus and up to five logical devices on an expansion card. For every device it compares the 16-bit I/O address with that device's programmed base, over a number of upper address bits chosen by the device's own 3-bit block-size code. It then drives an active-low chip select while the address is inside the window, the device is active and the bus is not in a DMA cycle. The chip select, the output-enable lines and the range-check data are purely combinational from the inputs.

Two output-enable lines can each be steered, through a 3-bit code, to the I/O reads of one chosen device. In two-device mode only devices 0 and 1 exist, the second output-enable line is not used, and one extra code steers the first line to reads of either device. An inactive device can be put into a range-check mode. In that mode it answers reads inside its window with a fixed byte pattern, so that configuration software can probe for address conflicts before it turns the device on.

Top module: `io_cs_decoder`

## Requirements
- R1: Block-size code k in 0..6 gives a window of 2^k bytes. Address bits 15 down to k are compared with the base, and base bits below k are ignored.
- R2: Block-size code 7 behaves as code 0, a single byte with all 16 bits compared.
- R3: `dev_cs_n[i]` is low exactly when device i exists in the current mode, its `dev_active` bit is 1, `io_aen` is 0 and the address is in its window. It follows the address with no clock.
- R4: While `io_aen` is 1, every chip select and both `oen_n` lines are high and `rchk_drive` is 0.
- R5: A device whose `dev_active` bit is 0 never pulls its chip select low and never causes an output-enable line to assert.
- R6: Range check is set by `dev_rchk` bits {enable, pattern}, where bit 1 enables and bit 0 selects the pattern. An inactive device with bit 1 set, on a read (`io_ior_n` low, `io_aen` low) inside its window, makes `rchk_drive` 1 with `rchk_data` 0x55 if bit 0 is 1 and 0xAA if bit 0 is 0. When `rchk_drive` is 0, `rchk_data` is 0x00.
- R7: Range check has no effect while the device is active or while its enable bit is 0, and it never answers with `io_ior_n` high.
- R8: In five-device mode (`five_dev_mode`=1), each 3-bit output-enable code (line 0 in `oen_cfg[2:0]`, line 1 in `oen_cfg[5:3]`) selects device 0..4 with codes 0..4. Codes 5..7 select no device.
- R9: In two-device mode, devices 2..4 never select and `oen_n[1]` stays high. Line 0 code 0 selects device 0, code 1 selects device 1, code 2 selects either, and other codes select none.
- R10: An output-enable line is low only while `io_ior_n` is low and the chip select of a device it selects is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| io_addr | input | 16 | ISA I/O address |
| io_aen | input | 1 | Address enable, high during DMA cycles |
| io_ior_n | input | 1 | I/O read strobe, active low |
| five_dev_mode | input | 1 | 1: five devices, 0: two devices |
| dev_base | input | 80 | Per-device base address, device i at bits 16i+15..16i |
| dev_size | input | 15 | Per-device block-size code, device i at bits 3i+2..3i |
| dev_active | input | 5 | Per-device active bit |
| dev_rchk | input | 10 | Per-device range-check {enable, pattern}, device i at bits 2i+1..2i |
| oen_cfg | input | 6 | Output-enable device codes, line j at bits 3j+2..3j |
| dev_cs_n | output | 5 | Per-device chip select, active low |
| oen_n | output | 2 | Output-enable lines, active low |
| rchk_data | output | 8 | Range-check answer byte |
| rchk_drive | output | 1 | High while the range-check byte is to be driven |

## Verification
The bench builds the decoder with its default parameters: five devices and a 16-bit address. With these values every block-size code, both operating modes and every output-enable code can be reached. The table assigns each device a different window size and base alignment, including a base with low bits set and the code-7 case. One inactive device is left in range check, so that neighbouring windows, edge addresses and DMA cycles are all covered in a single pass. The directed tests then sweep each size code at both edges of its window. They also try every output-enable code in both modes and flip the active and enable bits to show that range check answers only when both conditions allow it.

// File: rtl/io_dec_pkg.sv
// Package: shared constants for the I/O chip-select decoder.
// Assumes: 8-bit data bus; two output-enable lines; two-device mode keeps devices 0 and 1.
package io_dec_pkg;
    localparam int SIZE_CODE_W   = 3;
    localparam int OEN_CODE_W    = 3;
    localparam int OEN_LINES     = 2;
    localparam int RCHK_W        = 2;
    localparam int DATA_W        = 8;
    localparam int TWO_MODE_DEVS = 2;
    localparam logic [DATA_W-1:0] RCHK_PAT_ONE  = 8'h55;
    localparam logic [DATA_W-1:0] RCHK_PAT_ZERO = 8'hAA;
endpackage

// File: rtl/io_dec_window.sv
// Module: address-window comparator for one logical device.
// Compares the address with the base over the bits left by the block-size code.
// Assumes: code all-ones means a single byte; code values above the address width are not used.
module io_dec_window #(
    parameter int ADDR_W = 16,
    parameter int SZ_W   = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [SZ_W-1:0]   size_code,
    output logic              in_window
);
    logic [SZ_W-1:0]   low_bits;
    logic [ADDR_W-1:0] keep_mask;

    // Purpose: turn the size code into a mask of compared address bits.
    always_comb begin
        low_bits  = (size_code == '1) ? '0 : size_code;
        keep_mask = {ADDR_W{1'b1}} << low_bits;
    end

    // Purpose: flag a hit when all kept bits agree with the base.
    always_comb begin
        in_window = (((addr ^ base) & keep_mask) == '0);
    end
endmodule

// File: rtl/io_dec_oen_sel.sv
// Module: turns one output-enable code into a set of selected devices.
// Five-device mode: code n picks device n. Two-device mode: 0, 1 or both.
// Assumes: codes that name no device select nothing.
module io_dec_oen_sel #(
    parameter int N_DEV  = 5,
    parameter int CODE_W = 3
) (
    input  logic [CODE_W-1:0] code,
    input  logic              five_mode,
    output logic [N_DEV-1:0]  dev_sel
);
    // Purpose: decode the code according to the operating mode.
    always_comb begin
        dev_sel = '0;
        if (five_mode) begin
            for (int i = 0; i < N_DEV; i++) begin
                dev_sel[i] = (int'(code) == i);
            end
        end else begin
            case (int'(code))
                0:       dev_sel[0] = 1'b1;
                1:       dev_sel[1] = 1'b1;
                2:       dev_sel[1:0] = 2'b11;
                default: dev_sel = '0;
            endcase
        end
    end
endmodule

// File: rtl/io_cs_decoder.sv
// Module: top of the I/O chip-select decoder.
// Drives per-device chip selects, steerable output enables and range-check answers.
// Assumes: all inputs are stable bus-side levels; the block is purely combinational.
module io_cs_decoder
    import io_dec_pkg::*;
#(
    parameter int N_DEV  = 5,
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0]             io_addr,
    input  logic                          io_aen,
    input  logic                          io_ior_n,
    input  logic                          five_dev_mode,
    input  logic [N_DEV*ADDR_W-1:0]       dev_base,
    input  logic [N_DEV*SIZE_CODE_W-1:0]  dev_size,
    input  logic [N_DEV-1:0]              dev_active,
    input  logic [N_DEV*RCHK_W-1:0]       dev_rchk,
    input  logic [OEN_LINES*OEN_CODE_W-1:0] oen_cfg,
    output logic [N_DEV-1:0]              dev_cs_n,
    output logic [OEN_LINES-1:0]          oen_n,
    output logic [DATA_W-1:0]             rchk_data,
    output logic                          rchk_drive
);
    logic [N_DEV-1:0] addr_hit;
    logic [N_DEV-1:0] dev_present;
    logic [N_DEV-1:0] dev_hit;
    logic [N_DEV-1:0] rchk_hit;
    logic             bus_read;

    // Purpose: a plain I/O read outside a DMA cycle.
    always_comb bus_read = !io_ior_n && !io_aen;

    for (genvar i = 0; i < N_DEV; i++) begin : g_dev
        io_dec_window #(.ADDR_W(ADDR_W), .SZ_W(SIZE_CODE_W)) u_win (
            .addr      (io_addr),
            .base      (dev_base[i*ADDR_W +: ADDR_W]),
            .size_code (dev_size[i*SIZE_CODE_W +: SIZE_CODE_W]),
            .in_window (addr_hit[i])
        );

        // Purpose: qualify the window hit by mode, active bit, DMA and range check.
        always_comb begin
            dev_present[i] = five_dev_mode || (i < TWO_MODE_DEVS);
            dev_hit[i]     = addr_hit[i] && dev_present[i] && dev_active[i] && !io_aen;
            dev_cs_n[i]    = !dev_hit[i];
            rchk_hit[i]    = addr_hit[i] && dev_present[i] && !dev_active[i]
                             && dev_rchk[i*RCHK_W + 1] && bus_read;
        end
    end

    for (genvar j = 0; j < OEN_LINES; j++) begin : g_oen
        logic [N_DEV-1:0] sel;
        logic             line_used;

        io_dec_oen_sel #(.N_DEV(N_DEV), .CODE_W(OEN_CODE_W)) u_sel (
            .code      (oen_cfg[j*OEN_CODE_W +: OEN_CODE_W]),
            .five_mode (five_dev_mode),
            .dev_sel   (sel)
        );

        // Purpose: assert the line on reads to a selected, hit device.
        always_comb begin
            line_used = (j == 0) || five_dev_mode;
            oen_n[j]  = !(line_used && !io_ior_n && |(sel & dev_hit));
        end
    end

    // Purpose: pick the answer pattern of the lowest-numbered probing device.
    always_comb begin
        rchk_data = '0;
        for (int i = N_DEV - 1; i >= 0; i--) begin
            if (rchk_hit[i]) begin
                rchk_data = dev_rchk[i*RCHK_W] ? RCHK_PAT_ONE : RCHK_PAT_ZERO;
            end
        end
        rchk_drive = |rchk_hit;
    end
endmodule

// File: rtl/io_cs_decoder_chk.sv
// Module: assertion checker for io_cs_decoder, bound to every instance.
// Uses immediate assertions because the decoder has no clock.
module io_cs_decoder_chk
    import io_dec_pkg::*;
#(
    parameter int N_DEV  = 5,
    parameter int ADDR_W = 16
) (
    input logic                          io_aen,
    input logic                          io_ior_n,
    input logic                          five_dev_mode,
    input logic [N_DEV-1:0]              dev_active,
    input logic [N_DEV*RCHK_W-1:0]       dev_rchk,
    input logic [N_DEV-1:0]              dev_cs_n,
    input logic [OEN_LINES-1:0]          oen_n,
    input logic [DATA_W-1:0]             rchk_data,
    input logic                          rchk_drive
);
    // Purpose: relate the outputs to the qualifying inputs.
    always_comb begin
        AST_AEN_BLOCKS: assert (!io_aen || ((&dev_cs_n) && (&oen_n) && !rchk_drive)); // R4
        AST_OEN_NEEDS_READ: assert (!io_ior_n || (&oen_n)); // R10
        AST_RCHK_PATTERN: assert (!rchk_drive || rchk_data == RCHK_PAT_ONE || rchk_data == RCHK_PAT_ZERO); // R6
        AST_RCHK_IDLE_ZERO: assert (rchk_drive || rchk_data == '0); // R6
        AST_RCHK_NEEDS_READ: assert (!rchk_drive || !io_ior_n); // R7
        AST_TWO_MODE_LINE1: assert (five_dev_mode || oen_n[1]); // R9
        for (int i = 0; i < N_DEV; i++) begin
            AST_INACTIVE_QUIET: assert (dev_active[i] || dev_cs_n[i]); // R5
            AST_TWO_MODE_UPPER: assert (five_dev_mode || i < TWO_MODE_DEVS || dev_cs_n[i]); // R9
            AST_RCHK_NEEDS_ENABLE: assert (!rchk_drive || |dev_rchk); // R7
        end
    end
endmodule

bind io_cs_decoder io_cs_decoder_chk #(.N_DEV(N_DEV), .ADDR_W(ADDR_W)) u_chk (
    .io_aen        (io_aen),
    .io_ior_n      (io_ior_n),
    .five_dev_mode (five_dev_mode),
    .dev_active    (dev_active),
    .dev_rchk      (dev_rchk),
    .dev_cs_n      (dev_cs_n),
    .oen_n         (oen_n),
    .rchk_data     (rchk_data),
    .rchk_drive    (rchk_drive)
);

// File: tb/tb_io_cs_decoder.sv
module tb_io_cs_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int N_DEV      = 5;
    localparam int NVEC       = 14;

    logic        clk = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_aen = 1'b0;
    logic        io_ior_n = 1'b1;
    logic        five_dev_mode = 1'b0;
    logic [79:0] dev_base = '0;
    logic [14:0] dev_size = '0;
    logic [4:0]  dev_active = '0;
    logic [9:0]  dev_rchk = '0;
    logic [5:0]  oen_cfg = '0;
    logic [4:0]  dev_cs_n;
    logic [1:0]  oen_n;
    logic [7:0]  rchk_data;
    logic        rchk_drive;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    io_cs_decoder #(.N_DEV(N_DEV), .ADDR_W(16)) dut (.*);

    always #(CLK_PERIOD/2) clk = !clk;

    // {addr, aen, ior_n, cs_n[4:0], oen_n[1:0], drive, data}
    localparam logic [33:0] VECS [0:NVEC-1] = '{
        {16'h0300, 1'b0, 1'b1, 5'b11110, 2'b11, 1'b0, 8'h00},
        {16'h0307, 1'b0, 1'b0, 5'b11110, 2'b01, 1'b0, 8'h00},
        {16'h0308, 1'b0, 1'b0, 5'b11111, 2'b11, 1'b0, 8'h00},
        {16'h0222, 1'b0, 1'b1, 5'b11101, 2'b11, 1'b0, 8'h00},
        {16'h0224, 1'b0, 1'b1, 5'b11111, 2'b11, 1'b0, 8'h00},
        {16'h0340, 1'b0, 1'b1, 5'b11011, 2'b11, 1'b0, 8'h00},
        {16'h0341, 1'b0, 1'b1, 5'b11111, 2'b11, 1'b0, 8'h00},
        {16'h03BF, 1'b0, 1'b0, 5'b10111, 2'b10, 1'b0, 8'h00},
        {16'h03C0, 1'b0, 1'b0, 5'b11111, 2'b11, 1'b0, 8'h00},
        {16'h0380, 1'b1, 1'b0, 5'b11111, 2'b11, 1'b0, 8'h00},
        {16'h0205, 1'b0, 1'b0, 5'b11111, 2'b11, 1'b1, 8'h55},
        {16'h0205, 1'b0, 1'b1, 5'b11111, 2'b11, 1'b0, 8'h00},
        {16'h0205, 1'b1, 1'b0, 5'b11111, 2'b11, 1'b0, 8'h00},
        {16'h0210, 1'b0, 1'b0, 5'b11111, 2'b11, 1'b0, 8'h00}
    };

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] a, input logic aen, input logic ior_n);
        @(negedge clk);
        io_addr  = a;
        io_aen   = aen;
        io_ior_n = ior_n;
        #2;
    endtask

    function automatic logic [15:0] outs();
        return {dev_cs_n, oen_n, rchk_drive, rchk_data};
    endfunction

    task automatic table_config();
        five_dev_mode = 1'b1;
        dev_base = {16'h0200, 16'h0380, 16'h0340, 16'h0223, 16'h0300};
        dev_size = {3'd4, 3'd6, 3'd7, 3'd1, 3'd3};
        dev_active = 5'b01111;
        dev_rchk = {2'b11, 2'b00, 2'b00, 2'b00, 2'b00};
        oen_cfg = {3'd0, 3'd3};
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 200000);
            finish_run();
        end
    end

    initial begin
        // Idle state: nothing configured, everything quiet (R5)
        apply(16'h0000, 1'b0, 1'b0);
        check("R5", "idle outputs", 32'(outs()), 32'({5'b11111, 2'b11, 1'b0, 8'h00}));

        // Vector table (R3 with R1, R2, R4, R6, R8, R10 cases inside)
        table_config();
        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] a; logic ae; logic ir; logic [15:0] exp;
            {a, ae, ir, exp} = VECS[v];
            apply(a, ae, ir);
            check("R3", $sformatf("vector %0d", v), 32'(outs()), 32'(exp));
        end

        // R1: each size code at both edges of its window on device 0
        for (int k = 0; k < 7; k++) begin
            table_config();
            dev_size[2:0] = 3'(k);
            apply(16'h0300 + 16'((1 << k) - 1), 1'b0, 1'b1);
            check("R1", $sformatf("code %0d last byte", k), 32'(dev_cs_n[0]), 32'd0);
            apply(16'h0300 + 16'(1 << k), 1'b0, 1'b1);
            check("R1", $sformatf("code %0d past end", k), 32'(dev_cs_n[0]), 32'd1);
        end

        // R2: code 7 compares every bit
        table_config();
        apply(16'h0340, 1'b0, 1'b1);
        check("R2", "code 7 base", 32'(dev_cs_n[2]), 32'd0);
        apply(16'h0341, 1'b0, 1'b1);
        check("R2", "code 7 base+1", 32'(dev_cs_n[2]), 32'd1);

        // R4: DMA cycle blocks a read that would hit with output enable
        apply(16'h0307, 1'b1, 1'b0);
        check("R4", "aen read", 32'(outs()), 32'({5'b11111, 2'b11, 1'b0, 8'h00}));

        // R5: deactivate device 0, read in its window with line 1 pointing at it
        dev_active[0] = 1'b0;
        apply(16'h0302, 1'b0, 1'b0);
        check("R5", "inactive read", 32'({dev_cs_n[0], oen_n}), 32'({1'b1, 2'b11}));

        // R6: pattern 0xAA when bit 0 is clear
        table_config();
        dev_rchk[9:8] = 2'b10;
        apply(16'h020F, 1'b0, 1'b0);
        check("R6", "pattern AA", 32'({rchk_drive, rchk_data}), 32'({1'b1, 8'hAA}));

        // R7: active device ignores range check; disabled enable ignores it
        dev_active[4] = 1'b1;
        dev_rchk[9:8] = 2'b11;
        apply(16'h0205, 1'b0, 1'b0);
        check("R7", "active with rchk", 32'({dev_cs_n[4], rchk_drive, rchk_data}), 32'({1'b0, 1'b0, 8'h00}));
        dev_active[4] = 1'b0;
        dev_rchk[9:8] = 2'b01;
        apply(16'h0205, 1'b0, 1'b0);
        check("R7", "enable clear", 32'({rchk_drive, rchk_data}), 32'({1'b0, 8'h00}));

        // R8: every line 0 code in five-device mode, all devices active
        table_config();
        dev_active = 5'b11111;
        dev_rchk = '0;
        for (int c = 0; c < 8; c++) begin
            logic [15:0] hit_addr [0:4];
            hit_addr = '{16'h0300, 16'h0222, 16'h0340, 16'h0390, 16'h0208};
            oen_cfg = {3'd7, 3'(c)};
            for (int d = 0; d < 5; d++) begin
                apply(hit_addr[d], 1'b0, 1'b0);
                check("R8", $sformatf("code %0d dev %0d", c, d), 32'(oen_n[0]), 32'(!(c == d)));
            end
        end

        // R10: output enable follows the read strobe
        oen_cfg = {3'd7, 3'd1};
        apply(16'h0222, 1'b0, 1'b1);
        check("R10", "strobe high", 32'(oen_n[0]), 32'd1);
        apply(16'h0222, 1'b0, 1'b0);
        check("R10", "strobe low", 32'(oen_n[0]), 32'd0);

        // R9: two-device mode
        five_dev_mode = 1'b0;
        oen_cfg = {3'd0, 3'd2};
        apply(16'h0340, 1'b0, 1'b0);
        check("R9", "device 2 absent", 32'(dev_cs_n), 32'h1F);
        apply(16'h0300, 1'b0, 1'b0);
        check("R9", "either code dev0", 32'({dev_cs_n[0], oen_n}), 32'({1'b0, 2'b10}));
        apply(16'h0222, 1'b0, 1'b0);
        check("R9", "either code dev1", 32'({dev_cs_n[1], oen_n}), 32'({1'b0, 2'b10}));
        oen_cfg = {3'd0, 3'd3};
        apply(16'h0300, 1'b0, 1'b0);
        check("R9", "code 3 none", 32'(oen_n), 32'(2'b11));
        oen_cfg = {3'd0, 3'd1};
        apply(16'h0300, 1'b0, 1'b0);
        check("R9", "code 1 on dev0", 32'(oen_n[0]), 32'd1);

        finish_run();
    end
endmodule